// File: doc/BRIEF.md
# Transactional Cache Line State Tracker

This block keeps the coherence state of a small, fully associative group of cache lines. Each line also carries a one-bit transaction mark. It is the bookkeeping half of hardware transactional memory. A transaction opens with a begin command, and at that moment the block copies the architectural register file. While the transaction runs, every local write hit marks its line and takes it to Modified. A commit drops all marks in one cycle and leaves the lines as they are. An abort turns every marked line Invalid in one cycle and hands back the saved register copy, so other cores never see the cancelled stores.

An abort can come from three places. One is an explicit command with an 8-bit reason code. Another is an interrupt, trap or exception event. The third is an overflow: a write that would mark one line more than the capacity limit. A line that was already Modified before the transaction opened is protected. The first transactional write to such a line raises a writeback request in that same cycle, so the line's earlier data is cleaned out before it can be cancelled. Snoops from other cores are plain request and response signals. A snoop to a marked line is held with a wait signal until the transaction ends. Any other snoop is granted at once and invalidates the line. One cycle after every transaction ends, a status pulse reports its outcome.

Top module: `txn_line_tracker`

## Requirements
- R1: After reset every line is Invalid with its mark clear, `tx_active` is 0 and `st_valid` is 0. The line state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: `tx_begin` while idle stores `rf_in`. After an abort, `rf_restore_valid` is 1 for the single cycle in which `st_valid` is 1, and `rf_restore` then equals the stored value. A commit leaves `rf_restore_valid` at 0.
- R3: During a transaction, a write to a line that is not Invalid sets the line to Modified with its mark set. If that line was Modified with its mark clear, `wb_req` is 1 with `wb_idx` equal to the line in that same cycle.
- R4: A commit clears every mark and leaves every line state unchanged. In the next cycle `st_valid` is 1 with `st_cause`=0 and `st_code`=0.
- R5: An abort makes every marked line Invalid and clears its mark. Unmarked lines keep their state, including lines that were Modified before the transaction and were not written during it.
- R6: While a transaction is active, a snoop to a marked line gives `snp_wait`=1 and `snp_ack`=0 for as long as the transaction lasts.
- R7: A snoop that is not held gives `snp_ack`=1 in the same cycle, with `snp_dirty`=1 if the line is Modified. The line is Invalid in the following cycle.
- R8: `tx_abort` during a transaction ends it with `st_cause`=1 and `st_code` equal to `tx_abort_code`.
- R9: `trap_event` during a transaction ends it with `st_cause`=2. It wins over a `tx_abort` in the same cycle. When idle it has no effect.
- R10: Up to CAP distinct lines may be marked. A write that would mark line CAP+1 aborts with `st_cause`=3 and leaves its target line unchanged. Rewriting a line that is already marked does not count toward the limit.
- R11: `st_valid` stays high for exactly one cycle. `tx_commit` and `tx_abort` while idle produce no status.
- R12: A write hit outside a transaction makes the line Modified with its mark clear and raises no `wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the transaction |
| tx_abort | input | 1 | Explicit abort |
| tx_abort_code | input | 8 | Reason code for an explicit abort |
| trap_event | input | 1 | Interrupt, trap or exception |
| rf_in | input | REGS*REG_W | Live register file contents |
| rf_restore_valid | output | 1 | Register file must be restored |
| rf_restore | output | REGS*REG_W | Saved register file |
| ld_valid | input | 1 | Install a state on a line |
| ld_idx | input | log2(LINES) | Line to install |
| ld_state | input | 2 | State to install |
| wr_valid | input | 1 | Local write |
| wr_idx | input | log2(LINES) | Line written |
| wb_req | output | 1 | Clean a pre-dirty line |
| wb_idx | output | log2(LINES) | Line to clean |
| snp_req | input | 1 | Snoop request from another core |
| snp_idx | input | log2(LINES) | Snooped line |
| snp_ack | output | 1 | Snoop granted |
| snp_wait | output | 1 | Snoop held |
| snp_dirty | output | 1 | Granted line held dirty data |
| probe_idx | input | log2(LINES) | Line to observe |
| probe_state | output | 2 | State of the probed line |
| probe_t | output | 1 | Mark of the probed line |
| tx_active | output | 1 | Transaction in progress |
| st_valid | output | 1 | Outcome pulse |
| st_cause | output | 2 | 0 commit, 1 explicit, 2 trap, 3 capacity |
| st_code | output | 8 | Explicit abort code, else 0 |

## Verification
The bench opens a transaction over a line that was Modified beforehand and over one that was not, then aborts it. A design that treated every Modified line as transactional would lose the older dirty line. One that skipped the writeback would leave the pre-dirty data unprotected. The bench keeps a snoop to a marked line waiting across several cycles and the commit. This catches a design that answers early or that never releases the wait. It fills the capacity exactly, rewrites a line that is already marked, and then adds one more line. An off-by-one limit shows up here as an early or a missing abort. Simultaneous trap and explicit abort, and end commands sent while idle, expose a wrong priority or a stray status pulse.

// File: rtl/txn_line_tracker.sv
module txn_line_tracker #(
  parameter int LINES = 8,
  parameter int CAP   = 4,
  parameter int REGS  = 4,
  parameter int REG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_begin,
  input  logic                       tx_commit,
  input  logic                       tx_abort,
  input  logic [7:0]                 tx_abort_code,
  input  logic                       trap_event,
  input  logic [REGS*REG_W-1:0]      rf_in,
  output logic                       rf_restore_valid,
  output logic [REGS*REG_W-1:0]      rf_restore,
  input  logic                       ld_valid,
  input  logic [$clog2(LINES)-1:0]   ld_idx,
  input  logic [1:0]                 ld_state,
  input  logic                       wr_valid,
  input  logic [$clog2(LINES)-1:0]   wr_idx,
  output logic                       wb_req,
  output logic [$clog2(LINES)-1:0]   wb_idx,
  input  logic                       snp_req,
  input  logic [$clog2(LINES)-1:0]   snp_idx,
  output logic                       snp_ack,
  output logic                       snp_wait,
  output logic                       snp_dirty,
  input  logic [$clog2(LINES)-1:0]   probe_idx,
  output logic [1:0]                 probe_state,
  output logic                       probe_t,
  output logic                       tx_active,
  output logic                       st_valid,
  output logic [1:0]                 st_cause,
  output logic [7:0]                 st_code
);
  localparam int CW = $clog2(CAP + 2);
  localparam logic [1:0] ST_I = 2'd0, ST_M = 2'd3;

  logic [1:0]            st_q [LINES];
  logic [LINES-1:0]      t_q;
  logic [CW-1:0]         cnt_q;
  logic [REGS*REG_W-1:0] snap_q;

  logic wr_hit, new_line, overflow;
  logic end_trap, end_expl, end_cap, end_commit, aborting;

  assign wr_hit     = wr_valid && (st_q[wr_idx] != ST_I);
  assign new_line   = wr_hit && tx_active && !t_q[wr_idx];
  assign overflow   = new_line && (cnt_q == CW'(CAP));
  assign end_trap   = tx_active && trap_event;
  assign end_expl   = tx_active && tx_abort && !trap_event;
  assign end_cap    = tx_active && overflow && !trap_event && !tx_abort;
  assign end_commit = tx_active && tx_commit && !trap_event && !tx_abort && !overflow;
  assign aborting   = end_trap || end_expl || end_cap;

  assign wb_req    = tx_active && wr_hit && (st_q[wr_idx] == ST_M) && !t_q[wr_idx] && !aborting;
  assign wb_idx    = wr_idx;
  assign snp_wait  = snp_req && tx_active && t_q[snp_idx];
  assign snp_ack   = snp_req && !snp_wait;
  assign snp_dirty = snp_ack && (st_q[snp_idx] == ST_M);

  assign probe_state = st_q[probe_idx];
  assign probe_t     = t_q[probe_idx];
  assign rf_restore  = snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
      t_q              <= '0;
      cnt_q            <= '0;
      snap_q           <= '0;
      tx_active        <= 1'b0;
      st_valid         <= 1'b0;
      st_cause         <= 2'd0;
      st_code          <= 8'd0;
      rf_restore_valid <= 1'b0;
    end else begin
      st_valid         <= 1'b0;
      rf_restore_valid <= 1'b0;

      if (ld_valid && !t_q[ld_idx]) st_q[ld_idx] <= ld_state;
      if (snp_ack) st_q[snp_idx] <= ST_I;

      if (wr_hit && !aborting) begin
        st_q[wr_idx] <= ST_M;
        if (tx_active) t_q[wr_idx] <= 1'b1;
        if (new_line) cnt_q <= cnt_q + 1'b1;
      end

      if (!tx_active && tx_begin) begin
        tx_active <= 1'b1;
        snap_q    <= rf_in;
        cnt_q     <= '0;
      end

      if (end_commit) begin
        tx_active <= 1'b0;
        t_q       <= '0;
        cnt_q     <= '0;
        st_valid  <= 1'b1;
        st_cause  <= 2'd0;
        st_code   <= 8'd0;
      end

      if (aborting) begin
        for (int i = 0; i < LINES; i++)
          if (t_q[i]) st_q[i] <= ST_I;
        t_q              <= '0;
        cnt_q            <= '0;
        tx_active        <= 1'b0;
        st_valid         <= 1'b1;
        rf_restore_valid <= 1'b1;
        st_cause         <= end_trap ? 2'd2 : (end_expl ? 2'd1 : 2'd3);
        st_code          <= end_expl ? tx_abort_code : 8'd0;
      end
    end
  end
endmodule

// File: rtl/txn_line_tracker_chk.sv
module txn_line_tracker_chk #(
  parameter int LINES = 8,
  parameter int CAP   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_active,
  input logic             tx_commit,
  input logic             tx_abort,
  input logic             trap_event,
  input logic             st_valid,
  input logic [1:0]       st_cause,
  input logic             rf_restore_valid,
  input logic             snp_wait,
  input logic             snp_ack,
  input logic             wb_req,
  input logic [LINES-1:0] t_q
);
  assert_restore_on_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_restore_valid |-> (st_valid && st_cause != 2'd0));

  assert_wb_only_in_txn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> tx_active);

  assert_end_reports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && (tx_commit || tx_abort || trap_event)) |=> (st_valid && !tx_active));

  assert_marks_clear_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (t_q == '0));

  assert_wait_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wait |-> !snp_ack);

  assert_cap_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_q) <= CAP);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);
endmodule

bind txn_line_tracker txn_line_tracker_chk #(.LINES(LINES), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .tx_commit(tx_commit),
  .tx_abort(tx_abort), .trap_event(trap_event), .st_valid(st_valid),
  .st_cause(st_cause), .rf_restore_valid(rf_restore_valid), .snp_wait(snp_wait),
  .snp_ack(snp_ack), .wb_req(wb_req), .t_q(t_q)
);

// File: tb/txn_line_tracker_bench.sv
module txn_line_tracker_bench;
  localparam int CLK_P = 10;
  localparam int LINES = 8;
  localparam int CAP   = 4;
  localparam int RW    = 64;
  localparam int IW    = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, trap_event = 0;
  logic [7:0] tx_abort_code = 0;
  logic [RW-1:0] rf_in = 0, rf_restore;
  logic rf_restore_valid;
  logic ld_valid = 0; logic [IW-1:0] ld_idx = 0; logic [1:0] ld_state = 0;
  logic wr_valid = 0; logic [IW-1:0] wr_idx = 0;
  logic wb_req; logic [IW-1:0] wb_idx;
  logic snp_req = 0; logic [IW-1:0] snp_idx = 0;
  logic snp_ack, snp_wait, snp_dirty;
  logic [IW-1:0] probe_idx = 0; logic [1:0] probe_state; logic probe_t;
  logic tx_active, st_valid; logic [1:0] st_cause; logic [7:0] st_code;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  txn_line_tracker #(.LINES(LINES), .CAP(CAP), .REGS(4), .REG_W(16)) u_txn_line_tracker (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .tx_abort_code(tx_abort_code), .trap_event(trap_event),
    .rf_in(rf_in), .rf_restore_valid(rf_restore_valid), .rf_restore(rf_restore),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_state(ld_state),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wb_req(wb_req), .wb_idx(wb_idx),
    .snp_req(snp_req), .snp_idx(snp_idx), .snp_ack(snp_ack), .snp_wait(snp_wait),
    .snp_dirty(snp_dirty), .probe_idx(probe_idx), .probe_state(probe_state),
    .probe_t(probe_t), .tx_active(tx_active), .st_valid(st_valid),
    .st_cause(st_cause), .st_code(st_code));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic probe(input int idx, input logic [1:0] st, input logic t, input string req);
    probe_idx = IW'(idx); #1;
    eq({req, " state"}, 64'(probe_state), 64'(st));
    eq({req, " mark"}, 64'(probe_t), 64'(t));
  endtask

  task automatic load(input int idx, input logic [1:0] st);
    ld_valid = 1; ld_idx = IW'(idx); ld_state = st; step(); ld_valid = 0;
  endtask

  task automatic write(input int idx);
    wr_valid = 1; wr_idx = IW'(idx); step(); wr_valid = 0;
  endtask

  task automatic begin_tx(input logic [RW-1:0] regs);
    tx_begin = 1; rf_in = regs; step(); tx_begin = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < LINES; i++) probe(i, 2'd0, 1'b0, "R1 reset line");
    eq("R1 tx_active after reset", 64'(tx_active), 0);
    eq("R1 st_valid after reset", 64'(st_valid), 0);
  endtask

  task automatic t_idle_write();
    load(0, 2'd1);
    wr_valid = 1; wr_idx = 0; #1;
    eq("R12 no wb outside txn", 64'(wb_req), 0);
    step(); wr_valid = 0;
    probe(0, 2'd3, 1'b0, "R12 idle write");
  endtask

  task automatic t_commit();
    load(1, 2'd2); load(2, 2'd3);
    begin_tx(64'h1111_2222_3333_4444);
    eq("R2 active after begin", 64'(tx_active), 1);
    wr_valid = 1; wr_idx = 1; #1;
    eq("R3 no wb for clean line", 64'(wb_req), 0);
    step(); wr_valid = 0;
    probe(1, 2'd3, 1'b1, "R3 txn write clean");
    wr_valid = 1; wr_idx = 2; #1;
    eq("R3 wb for pre-dirty line", 64'(wb_req), 1);
    eq("R3 wb index", 64'(wb_idx), 2);
    step(); wr_valid = 0;
    probe(2, 2'd3, 1'b1, "R3 txn write dirty");
    tx_commit = 1; step(); tx_commit = 0;
    eq("R4 commit status valid", 64'(st_valid), 1);
    eq("R4 commit cause", 64'(st_cause), 0);
    eq("R4 commit code", 64'(st_code), 0);
    eq("R2 no restore on commit", 64'(rf_restore_valid), 0);
    probe(1, 2'd3, 1'b0, "R4 committed line");
    probe(2, 2'd3, 1'b0, "R4 committed line");
    step();
    eq("R11 status one cycle", 64'(st_valid), 0);
  endtask

  task automatic t_abort_explicit();
    load(3, 2'd3); load(4, 2'd2); load(5, 2'd1);
    begin_tx(64'hABCD_0123_4567_89EF);
    rf_in = 64'hDEAD_BEEF_DEAD_BEEF;
    write(4);
    tx_abort = 1; tx_abort_code = 8'h5A; step(); tx_abort = 0;
    eq("R8 abort status valid", 64'(st_valid), 1);
    eq("R8 abort cause", 64'(st_cause), 1);
    eq("R8 abort code", 64'(st_code), 64'h5A);
    eq("R2 restore valid", 64'(rf_restore_valid), 1);
    eq("R2 restore data", rf_restore, 64'hABCD_0123_4567_89EF);
    eq("R8 inactive after abort", 64'(tx_active), 0);
    probe(4, 2'd0, 1'b0, "R5 written line dropped");
    probe(3, 2'd3, 1'b0, "R5 pre-dirty line kept");
    probe(5, 2'd1, 1'b0, "R5 shared line kept");
    step();
    eq("R2 restore one cycle", 64'(rf_restore_valid), 0);
  endtask

  task automatic t_snoop();
    load(6, 2'd2); load(7, 2'd1);
    begin_tx(64'h5);
    write(6);
    snp_req = 1; snp_idx = 6; #1;
    eq("R6 held wait", 64'(snp_wait), 1);
    eq("R6 held no ack", 64'(snp_ack), 0);
    step();
    eq("R6 still waiting", 64'(snp_wait), 1);
    snp_idx = 7; #1;
    eq("R7 unmarked ack", 64'(snp_ack), 1);
    eq("R7 unmarked no wait", 64'(snp_wait), 0);
    eq("R7 shared not dirty", 64'(snp_dirty), 0);
    step();
    probe(7, 2'd0, 1'b0, "R7 snooped line invalid");
    snp_idx = 6; tx_commit = 1; #1;
    eq("R6 waits in commit cycle", 64'(snp_wait), 1);
    step(); tx_commit = 0; #1;
    eq("R6 released after commit", 64'(snp_ack), 1);
    eq("R7 dirty on release", 64'(snp_dirty), 1);
    step(); snp_req = 0;
    probe(6, 2'd0, 1'b0, "R7 released line invalid");
  endtask

  task automatic t_trap();
    trap_event = 1; step(); trap_event = 0;
    eq("R9 idle trap no status", 64'(st_valid), 0);
    eq("R9 idle trap no txn", 64'(tx_active), 0);
    load(0, 2'd2);
    begin_tx(64'h77);
    write(0);
    trap_event = 1; tx_abort = 1; tx_abort_code = 8'h33; step();
    trap_event = 0; tx_abort = 0;
    eq("R9 trap cause wins", 64'(st_cause), 2);
    eq("R9 trap code zero", 64'(st_code), 0);
    eq("R9 trap restores", 64'(rf_restore_valid), 1);
    probe(0, 2'd0, 1'b0, "R9 trap invalidates");
  endtask

  task automatic t_capacity();
    for (int i = 0; i < 6; i++) load(i, 2'd2);
    begin_tx(64'h99);
    for (int i = 0; i < CAP; i++) write(i);
    write(0);
    eq("R10 full capacity still active", 64'(tx_active), 1);
    eq("R10 no early status", 64'(st_valid), 0);
    write(CAP);
    eq("R10 overflow status", 64'(st_valid), 1);
    eq("R10 overflow cause", 64'(st_cause), 3);
    eq("R10 overflow ends txn", 64'(tx_active), 0);
    probe(CAP, 2'd2, 1'b0, "R10 overflow target untouched");
    for (int i = 0; i < CAP; i++) probe(i, 2'd0, 1'b0, "R10 marked lines dropped");
  endtask

  task automatic t_stray();
    step();
    tx_commit = 1; step(); tx_commit = 0;
    eq("R11 idle commit no status", 64'(st_valid), 0);
    tx_abort = 1; step(); tx_abort = 0;
    eq("R11 idle abort no status", 64'(st_valid), 0);
    eq("R11 idle abort no restore", 64'(rf_restore_valid), 0);
  endtask

  initial begin
    step(); step();
    rst_n = 1; step();
    t_reset();
    t_idle_write();
    t_commit();
    t_abort_explicit();
    t_snoop();
    t_trap();
    t_capacity();
    t_stray();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule